// File: doc/BRIEF.md
# Serial command frame parser

The parser sits behind a UART receiver. It takes one received byte at a time, marked by a valid strobe, and assembles six-byte command frames from them. A frame is accepted only when its first byte is the start marker 0xAB. After the marker come a one-byte command code, a three-byte address with its most significant byte first, and a one-byte data value.

When the sixth byte of an accepted frame arrives, the parser presents the command code, the 24-bit address and the data byte on parallel outputs. It also raises a frame-valid pulse for one clock. If the first byte is not the marker, the parser keeps hunting: every later byte is tested as a possible marker, and a rejected byte changes no output. Downstream logic latches the fields on the pulse, or reads them at any later time, because they hold until the next accepted frame.

Top module: `cmd_frame_parser`

## Requirements
- R1: After a synchronous reset (rst_n low for at least two clocks), frame_valid is 0 and cmd_code, cmd_addr and cmd_data are all 0.
- R2: For the bytes 0xAB, C, A2, A1, A0, D, the parser outputs cmd_code = C, cmd_addr = {A2, A1, A0} (the first address byte is bits 23:16) and cmd_data = D. For example, AB 01 00 1F FF 40 gives 0x01, 0x001FFF and 0x40.
- R3: In the hunt state, a byte other than 0xAB is dropped and the parser stays in the hunt state, so each following byte is tested as a start. The stream 0A 02 00 1F FF AD produces no pulse and changes no output.
- R4: frame_valid is 1 for exactly one clock. It is 1 in the cycle that follows the rising edge on which the sixth byte of an accepted frame is sampled, and at no other time.
- R5: cmd_code, cmd_addr and cmd_data change only together with a frame_valid pulse. Between pulses they hold their values, including through rejected bytes and idle cycles.
- R6: After a start byte, the next five bytes are frame content whatever their value. A 0xAB among them is data and does not restart the frame.
- R7: Every command code value 0x00 to 0xFF is passed through unchanged. This includes 0x01 (program), 0x02 (read) and 0x03 (reset).
- R8: The parser ignores any cycle with rx_valid low, whatever is on rx_byte. The number of idle cycles between bytes does not affect the result.
- R9: A reset in the middle of a frame discards the bytes received so far. The bytes that follow need a fresh 0xAB before any frame is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_valid | input | 1 | rx_byte carries a new received byte this cycle |
| rx_byte | input | 8 | Received byte |
| frame_valid | output | 1 | One-clock pulse when an accepted frame is complete |
| cmd_code | output | 8 | Command code of the last accepted frame |
| cmd_addr | output | 24 | Address of the last accepted frame |
| cmd_data | output | 8 | Data byte of the last accepted frame |

## Verification
The assertions assume the following about the inputs:
- Reset is held low for at least two clocks, so that the hold check and the past-value checks see cleared outputs on the first cycle after reset.
- A byte counts only in a cycle where rx_valid is high.

The stimulus changes inputs only on falling edges and always starts with a multi-cycle reset. It places junk values, including 0xAB, on rx_byte during idle cycles. It sweeps every first-byte value and every command code.

// File: rtl/frame_pkg.sv
// Package: shared constants and helpers for the command frame parser.
// Assumes a frame is marker, code, address bytes, data (three fixed bytes).
package frame_pkg;
    localparam int FIXED_BYTES = 3;

    // Total frame length for a given number of address bytes.
    function automatic int frame_len(input int addr_bytes);
        return addr_bytes + FIXED_BYTES;
    endfunction
endpackage

// File: rtl/frame_seq.sv
// Module: frame position sequencer. Position 0 is the hunt state, which
// waits for the start marker. Positions 1..LAST step through the body bytes.
// Assumes a byte is present only when rx_valid is high.
module frame_seq #(
    parameter int          BYTE_W      = 8,
    parameter int          FRAME_BYTES = 6,
    parameter logic [7:0]  START_CODE  = 8'hAB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic              store,
    output logic              done
);
    localparam int POS_W = $clog2(FRAME_BYTES);
    localparam logic [POS_W-1:0] LAST = POS_W'(FRAME_BYTES - 1);

    logic [POS_W-1:0] pos;

    // Advance the position on each byte; in hunt, advance only on the marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos <= '0;
        end else if (rx_valid) begin
            if (pos == '0) begin
                if (rx_byte == BYTE_W'(START_CODE)) pos <= POS_W'(1);
            end else if (pos == LAST) begin
                pos <= '0;
            end else begin
                pos <= pos + POS_W'(1);
            end
        end
    end

    // Body bytes go to the field register; the last body byte closes the frame.
    always_comb begin
        store = rx_valid && (pos != '0);
        done  = rx_valid && (pos == LAST);
    end

    // R3: a non-marker byte seen in hunt leaves the parser in hunt.
    p_hunt_reject_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pos == '0 && rx_valid && rx_byte != BYTE_W'(START_CODE)) |=> (pos == '0));

    // R8: idle cycles do not move the position.
    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |=> $stable(pos));
endmodule

// File: rtl/frame_fields.sv
// Module: collects the body bytes and loads the output fields.
// The code and address bytes enter a shift register. When the final
// (data) byte arrives, all fields are loaded at once and the pulse is raised.
// Assumes store/done come from frame_seq, with done only on a stored byte.
module frame_fields #(
    parameter int BYTE_W     = 8,
    parameter int ADDR_BYTES = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         store,
    input  logic                         done,
    input  logic [BYTE_W-1:0]            rx_byte,
    output logic                         frame_valid,
    output logic [BYTE_W-1:0]            cmd_code,
    output logic [ADDR_BYTES*BYTE_W-1:0] cmd_addr,
    output logic [BYTE_W-1:0]            cmd_data
);
    localparam int ADDR_W = ADDR_BYTES * BYTE_W;
    localparam int BODY_W = ADDR_W + BYTE_W;

    logic [BODY_W-1:0] body;

    // Shift in code and address bytes, oldest ending in the top byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            body <= '0;
        end else if (store && !done) begin
            body <= {body[BODY_W-BYTE_W-1:0], rx_byte};
        end
    end

    // Load all fields and pulse on the closing byte; otherwise hold the fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_valid <= 1'b0;
            cmd_code    <= '0;
            cmd_addr    <= '0;
            cmd_data    <= '0;
        end else begin
            frame_valid <= done;
            if (done) begin
                cmd_code <= body[BODY_W-1 -: BYTE_W];
                cmd_addr <= body[ADDR_W-1:0];
                cmd_data <= rx_byte;
            end
        end
    end

    // R4: the pulse never lasts two clocks (a frame needs several bytes).
    p_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |=> !frame_valid);

    // R5: the fields move only with a pulse.
    p_fields_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_valid |-> ($stable(cmd_code) && $stable(cmd_addr) && $stable(cmd_data)));
endmodule

// File: rtl/cmd_frame_parser.sv
// Module: top of the serial command frame parser. It takes bytes from a UART
// receiver, finds marker-led frames and presents code, address and data with
// a one-clock valid pulse. Frames without the marker are dropped silently.
// Assumes rx_valid is high for one clock per received byte.
module cmd_frame_parser
    import frame_pkg::*;
#(
    parameter int         BYTE_W     = 8,
    parameter int         ADDR_BYTES = 3,
    parameter logic [7:0] START_CODE = 8'hAB
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         rx_valid,
    input  logic [BYTE_W-1:0]            rx_byte,
    output logic                         frame_valid,
    output logic [BYTE_W-1:0]            cmd_code,
    output logic [ADDR_BYTES*BYTE_W-1:0] cmd_addr,
    output logic [BYTE_W-1:0]            cmd_data
);
    localparam int FRAME_BYTES = frame_len(ADDR_BYTES);
    localparam int CNT_W       = $clog2(FRAME_BYTES + 1);

    logic store;
    logic done;

    frame_seq #(
        .BYTE_W      (BYTE_W),
        .FRAME_BYTES (FRAME_BYTES),
        .START_CODE  (START_CODE)
    ) i_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_valid (rx_valid),
        .rx_byte  (rx_byte),
        .store    (store),
        .done     (done)
    );

    frame_fields #(
        .BYTE_W     (BYTE_W),
        .ADDR_BYTES (ADDR_BYTES)
    ) i_fields (
        .clk         (clk),
        .rst_n       (rst_n),
        .store       (store),
        .done        (done),
        .rx_byte     (rx_byte),
        .frame_valid (frame_valid),
        .cmd_code    (cmd_code),
        .cmd_addr    (cmd_addr),
        .cmd_data    (cmd_data)
    );

    // Checker state: bytes received since the last pulse, saturating at frame length.
    logic [CNT_W-1:0] bytes_seen;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bytes_seen <= '0;
        end else if (frame_valid) begin
            bytes_seen <= rx_valid ? CNT_W'(1) : '0;
        end else if (rx_valid && bytes_seen != CNT_W'(FRAME_BYTES)) begin
            bytes_seen <= bytes_seen + CNT_W'(1);
        end
    end

    // R2: a pulse needs a full frame's worth of bytes since reset or the last pulse.
    p_full_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |-> (bytes_seen == CNT_W'(FRAME_BYTES)));

    // R8: a pulse always follows a cycle that carried a byte.
    p_pulse_after_byte_r8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |-> $past(rx_valid));
endmodule

// File: tb/test_cmd_frame_parser.sv
// Bench: self-checking sweep over first-byte values and command codes.
module test_cmd_frame_parser;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = 8'h00;
    logic        frame_valid;
    logic [7:0]  cmd_code;
    logic [23:0] cmd_addr;
    logic [7:0]  cmd_data;

    int total = 0;
    int bad = 0;
    int pulses = 0;
    logic [7:0]  e_code = 8'h00;
    logic [23:0] e_addr = 24'h0;
    logic [7:0]  e_data = 8'h00;

    always #2 clk = ~clk;

    cmd_frame_parser i_cmd_frame_parser (
        .clk (clk), .rst_n (rst_n), .rx_valid (rx_valid), .rx_byte (rx_byte),
        .frame_valid (frame_valid), .cmd_code (cmd_code),
        .cmd_addr (cmd_addr), .cmd_data (cmd_data)
    );

    // Count every pulse, sampled away from the active edge.
    always @(negedge clk) if (rst_n && frame_valid) pulses++;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One byte with rx_valid high, then gap idle cycles carrying junk (0xAB).
    task automatic put(input logic [7:0] b, input int gap);
        @(negedge clk); rx_valid = 1'b1; rx_byte = b;
        for (int g = 0; g < gap; g++) begin
            @(negedge clk); rx_valid = 1'b0; rx_byte = 8'hAB;
        end
    endtask

    // Send six bytes, most significant first, then stop driving.
    task automatic send6(input logic [47:0] f, input int gap);
        for (int k = 5; k >= 0; k--) put(f[k*8 +: 8], (k == 0) ? 0 : gap);
        @(negedge clk); rx_valid = 1'b0; rx_byte = 8'h00;
    endtask

    task automatic check_fields(input string req);
        check(req, {56'h0, cmd_code}, {56'h0, e_code});
        check(req, {40'h0, cmd_addr}, {40'h0, e_addr});
        check(req, {56'h0, cmd_data}, {56'h0, e_data});
    endtask

    // Valid frame: pulse in the cycle after the last byte, then gone.
    task automatic good_frame(input string req, input logic [7:0] c,
                              input logic [23:0] a, input logic [7:0] d, input int gap);
        send6({8'hAB, c, a, d}, gap);
        e_code = c; e_addr = a; e_data = d;
        check(req, {63'h0, frame_valid}, 64'h1);
        check_fields(req);
        @(negedge clk);
        check("R4 pulse width", {63'h0, frame_valid}, 64'h0);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; rx_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        e_code = 8'h00; e_addr = 24'h0; e_data = 8'h00;
    endtask

    initial begin
        int p0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset valid", {63'h0, frame_valid}, 64'h0);
        check_fields("R1 reset fields");

        good_frame("R2 example frame", 8'h01, 24'h001FFF, 8'h40, 0);

        p0 = pulses;
        send6(48'h0A02001FFFAD, 0);
        repeat (2) @(negedge clk);
        check("R3 bad marker no pulse", pulses - p0, 0);
        check_fields("R3 bad marker fields unchanged");
        check_fields("R5 hold after rejected bytes");

        // R3: hunting continues byte by byte; junk then a frame.
        put(8'h11, 0); put(8'h22, 0);
        good_frame("R3 start after junk", 8'h03, 24'h000010, 8'h99, 0);

        // R6: marker values inside the body are data.
        good_frame("R6 marker as data", 8'hAB, 24'hABABAB, 8'hAB, 0);

        // R8: gaps between bytes carrying junk on rx_byte.
        good_frame("R8 gapped bytes", 8'h02, 24'h123456, 8'h78, 3);

        // R3 sweep: every first byte; only 0xAB yields a frame.
        for (int b = 0; b < 256; b++) begin
            p0 = pulses;
            if (b == 8'hAB) begin
                good_frame("R3 sweep marker", 8'h02, 24'h102030, 8'h44, 0);
            end else begin
                send6({b[7:0], 40'h0110203044}, 0);
                repeat (2) @(negedge clk);
                check("R3 sweep rejected", pulses - p0, 0);
                check_fields("R5 sweep hold");
            end
        end

        // R7 sweep: every command code passes through.
        for (int c = 0; c < 256; c++) begin
            logic [7:0] cc;
            cc = c[7:0];
            good_frame("R7 code sweep", cc, {cc, ~cc, cc ^ 8'h5A}, cc + 8'h01, c % 2);
        end

        // R5: idle time does not disturb the fields.
        repeat (10) @(negedge clk);
        check_fields("R5 hold idle");

        // R9: reset mid-frame drops the partial frame.
        p0 = pulses;
        put(8'hAB, 0); put(8'h01, 0); put(8'h02, 0);
        do_reset();
        put(8'h03, 0); put(8'h04, 0); put(8'h05, 0); put(8'h06, 0);
        repeat (3) @(negedge clk);
        rx_valid = 1'b0;
        repeat (2) @(negedge clk);
        check("R9 no pulse after reset", pulses - p0, 0);
        check_fields("R9 fields cleared");
        good_frame("R9 frame after reset", 8'h01, 24'hFEDCBA, 8'h5C, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule